// File: doc/BRIEF.md
# CSR Read-Modify-Write Access Unit

This unit carries out control/status register instructions against a small local bank of registers. Each accepted request names an operation (swap, bit-set or bit-clear, each in a register-source or a 5-bit immediate form), a register address, a source value, the 5-bit source field (register index or immediate), the destination index and the instruction's PC. The unit merges the new value into the selected register as `new = (old & ~mask) | (value & mask)`. One cycle later it returns the previous contents for the destination register, a read strobe and a write strobe for side effects, and a flush request that sends fetch to the next sequential instruction.

Whether a read or a write takes place depends only on the index fields (the destination index for swaps, the source field for set/clear). It never depends on the data. The request side is a valid/ready stream. `req_ready` is held high, so a request is taken on every cycle that `req_valid` is high, and there is never back-pressure. The response side is a one-cycle `rsp_valid` pulse per accepted request with no ready, because the pipeline always consumes it. Requests may arrive back to back, and each one sees the bank state left by its predecessor.

Top module: `csr_rmw_unit`

## Requirements
- R1: After reset every bank register reads 0 and `rsp_valid`, `flush_req`, both strobes and `rsp_rd_we` are 0.
- R2: An accepted request produces its response exactly one cycle later (`rsp_valid`=1). A swap (op 3'b001) writes the source value, returns the old value on `rsp_rd_data`, and raises `csr_wr_stb`.
- R3: A swap with destination index 0 raises no `csr_rd_stb` and no `rsp_rd_we`, but still writes.
- R4: Set (op 3'b010) ORs the source into the register, and clear (op 3'b011) removes the source bits. Both return the old value.
- R5: Set or clear with source field 0 raises `csr_rd_stb` and returns the old value, raises no `csr_wr_stb`, and leaves the register unchanged even when `req_rs1_val` is nonzero.
- R6: Set or clear with a nonzero source field whose value is 0 still raises `csr_wr_stb`, and the register keeps its value.
- R7: Immediate forms (op 3'b101 swap, 3'b110 set, 3'b111 clear) use `req_field` zero-extended in place of `req_rs1_val`.
- R8: Every accepted request, legal or not, raises `flush_req` one cycle later, with `flush_pc` = `req_pc` + 4.
- R9: An address of `NUM_REGS` or above, or op 3'b000 / 3'b100, raises `rsp_illegal`, asserts no strobe and no `rsp_rd_we`, and changes no register.
- R10: `req_ready` is always 1. A request issued in the cycle right after another observes the first one's write.
- R11: `rsp_rd_we` is 1 only when a read takes place and the destination index is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_op | input | 3 | Operation code |
| req_addr | input | ADDR_W (12) | Register address |
| req_rs1_val | input | XLEN (32) | Source register value |
| req_field | input | 5 | Source index or immediate |
| req_rd | input | 5 | Destination index |
| req_pc | input | XLEN (32) | PC of the instruction |
| rsp_valid | output | 1 | Response pulse |
| rsp_illegal | output | 1 | Unmapped address or reserved op |
| rsp_rd_we | output | 1 | Destination write enable |
| rsp_rd_idx | output | 5 | Destination index |
| rsp_rd_data | output | XLEN (32) | Old register value |
| csr_rd_stb | output | 1 | Read side-effect strobe |
| csr_wr_stb | output | 1 | Write side-effect strobe |
| csr_stb_idx | output | IDX_W (2) | Register the strobes refer to |
| flush_req | output | 1 | Pipeline flush request |
| flush_pc | output | XLEN (32) | Fetch redirect target |

## Verification
A set or clear with a nonzero source field performs a read and a write in the same response. `rsp_rd_data` must then carry the pre-merge value while the bank already holds the merged one, and the following read-back must show the merge. The bench provokes this by issuing two requests on consecutive cycles to the same register. The second response must return the first request's result, and a final read-only access then confirms the combined effect. A second case puts the read strobe and the destination write enable in the same response: a read with destination 0 must strobe the read without writing the destination register.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;
  typedef enum logic [2:0] {
    OP_RSV0  = 3'b000,
    OP_SWAP  = 3'b001,
    OP_SET   = 3'b010,
    OP_CLR   = 3'b011,
    OP_RSV1  = 3'b100,
    OP_SWAPI = 3'b101,
    OP_SETI  = 3'b110,
    OP_CLRI  = 3'b111
  } csr_op_e;

  localparam int FIELD_W = 5;
endpackage

// File: rtl/csr_op_decode.sv
module csr_op_decode
  import csr_rmw_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int ADDR_W   = 12,
  parameter int NUM_REGS = 4,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic [2:0]         op,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [XLEN-1:0]    rs1_val,
  input  logic [FIELD_W-1:0] field,
  input  logic [FIELD_W-1:0] rd,
  output logic               legal,
  output logic               do_read,
  output logic               do_write,
  output logic [XLEN-1:0]    mask,
  output logic [XLEN-1:0]    value,
  output logic [IDX_W-1:0]   idx
);
  csr_op_e        kind;
  logic [XLEN-1:0] src;
  logic            mapped;
  logic            op_ok;
  logic            want_rd;
  logic            want_wr;

  assign kind   = csr_op_e'(op);
  assign src    = op[2] ? {{(XLEN-FIELD_W){1'b0}}, field} : rs1_val;
  assign mapped = (addr < ADDR_W'(NUM_REGS));
  assign idx    = addr[IDX_W-1:0];

  always_comb begin
    op_ok   = 1'b1;
    want_rd = 1'b0;
    want_wr = 1'b0;
    mask    = '0;
    value   = '0;
    unique case (kind)
      OP_SWAP, OP_SWAPI: begin
        mask    = '1;
        value   = src;
        want_rd = (rd != '0);
        want_wr = 1'b1;
      end
      OP_SET, OP_SETI: begin
        mask    = src;
        value   = '1;
        want_rd = 1'b1;
        want_wr = (field != '0);
      end
      OP_CLR, OP_CLRI: begin
        mask    = src;
        value   = '0;
        want_rd = 1'b1;
        want_wr = (field != '0);
      end
      default: op_ok = 1'b0;
    endcase
  end

  assign legal    = op_ok && mapped;
  assign do_read  = legal && want_rd;
  assign do_write = legal && want_wr;
endmodule

// File: rtl/csr_reg_bank.sv
module csr_reg_bank #(
  parameter int XLEN     = 32,
  parameter int NUM_REGS = 4,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [XLEN-1:0]  mask,
  input  logic [XLEN-1:0]  value,
  output logic [XLEN-1:0]  old_val
);
  logic [XLEN-1:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs[g] <= '0;
      end else if (wr_en && (idx == IDX_W'(g))) begin
        regs[g] <= (regs[g] & ~mask) | (value & mask);
      end
    end
  end

  assign old_val = regs[idx];
endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit
  import csr_rmw_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int ADDR_W   = 12,
  parameter int NUM_REGS = 4,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [XLEN-1:0]   req_rs1_val,
  input  logic [4:0]        req_field,
  input  logic [4:0]        req_rd,
  input  logic [XLEN-1:0]   req_pc,
  output logic              rsp_valid,
  output logic              rsp_illegal,
  output logic              rsp_rd_we,
  output logic [4:0]        rsp_rd_idx,
  output logic [XLEN-1:0]   rsp_rd_data,
  output logic              csr_rd_stb,
  output logic              csr_wr_stb,
  output logic [IDX_W-1:0]  csr_stb_idx,
  output logic              flush_req,
  output logic [XLEN-1:0]   flush_pc
);
  logic             legal;
  logic             do_read;
  logic             do_write;
  logic [XLEN-1:0]  mask;
  logic [XLEN-1:0]  value;
  logic [IDX_W-1:0] idx;
  logic [XLEN-1:0]  old_val;
  logic             take;

  assign req_ready = 1'b1;
  assign take      = req_valid && req_ready;

  csr_op_decode #(
    .XLEN(XLEN), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)
  ) u_dec (
    .op(req_op), .addr(req_addr), .rs1_val(req_rs1_val),
    .field(req_field), .rd(req_rd),
    .legal(legal), .do_read(do_read), .do_write(do_write),
    .mask(mask), .value(value), .idx(idx)
  );

  csr_reg_bank #(
    .XLEN(XLEN), .NUM_REGS(NUM_REGS)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(take && do_write),
    .idx(idx), .mask(mask), .value(value), .old_val(old_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_illegal <= 1'b0;
      rsp_rd_we   <= 1'b0;
      rsp_rd_idx  <= '0;
      rsp_rd_data <= '0;
      csr_rd_stb  <= 1'b0;
      csr_wr_stb  <= 1'b0;
      csr_stb_idx <= '0;
      flush_req   <= 1'b0;
      flush_pc    <= '0;
    end else begin
      rsp_valid   <= take;
      rsp_illegal <= take && !legal;
      rsp_rd_we   <= take && do_read && (req_rd != '0);
      csr_rd_stb  <= take && do_read;
      csr_wr_stb  <= take && do_write;
      flush_req   <= take;
      if (take) begin
        rsp_rd_idx  <= req_rd;
        rsp_rd_data <= do_read ? old_val : '0;
        csr_stb_idx <= idx;
        flush_pc    <= req_pc + XLEN'(4);
      end
    end
  end
endmodule

// File: rtl/csr_rmw_unit_checker.sv
module csr_rmw_unit_checker #(
  parameter int XLEN     = 32,
  parameter int ADDR_W   = 12,
  parameter int NUM_REGS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [2:0]        req_op,
  input logic [4:0]        req_field,
  input logic [4:0]        req_rd,
  input logic              rsp_valid,
  input logic              rsp_illegal,
  input logic              rsp_rd_we,
  input logic [4:0]        rsp_rd_idx,
  input logic              csr_rd_stb,
  input logic              csr_wr_stb,
  input logic              flush_req
);
  a_r8_flush_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && rst_n) |-> flush_req);

  a_r9_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_illegal |-> (!csr_rd_stb && !csr_wr_stb && !rsp_rd_we));

  a_r11_rdwe_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_rd_we |-> (csr_rd_stb && rsp_rd_idx != 5'd0));

  a_r3_swap_rd0_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_op[1:0] == 2'b01) && $past(req_rd == 5'd0)) |-> !csr_rd_stb);

  a_r5_field0_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_op[1]) && $past(req_field == 5'd0)) |-> !csr_wr_stb);

  a_r2_strobe_has_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rd_stb || csr_wr_stb || rsp_illegal) |-> rsp_valid);
endmodule

bind csr_rmw_unit csr_rmw_unit_checker #(
  .XLEN(XLEN), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .req_field(req_field), .req_rd(req_rd), .rsp_valid(rsp_valid),
  .rsp_illegal(rsp_illegal), .rsp_rd_we(rsp_rd_we), .rsp_rd_idx(rsp_rd_idx),
  .csr_rd_stb(csr_rd_stb), .csr_wr_stb(csr_wr_stb), .flush_req(flush_req)
);

// File: tb/csr_rmw_unit_test.sv
module csr_rmw_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = '0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_rs1_val = '0;
  logic [4:0]  req_field = '0;
  logic [4:0]  req_rd = '0;
  logic [31:0] req_pc = '0;
  logic        rsp_valid, rsp_illegal, rsp_rd_we, csr_rd_stb, csr_wr_stb, flush_req;
  logic [4:0]  rsp_rd_idx;
  logic [31:0] rsp_rd_data, flush_pc;
  logic [1:0]  csr_stb_idx;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  csr_rmw_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_rs1_val(req_rs1_val),
    .req_field(req_field), .req_rd(req_rd), .req_pc(req_pc),
    .rsp_valid(rsp_valid), .rsp_illegal(rsp_illegal), .rsp_rd_we(rsp_rd_we),
    .rsp_rd_idx(rsp_rd_idx), .rsp_rd_data(rsp_rd_data), .csr_rd_stb(csr_rd_stb),
    .csr_wr_stb(csr_wr_stb), .csr_stb_idx(csr_stb_idx), .flush_req(flush_req),
    .flush_pc(flush_pc)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [2:0] op, logic [11:0] a, logic [31:0] v,
                       logic [4:0] f, logic [4:0] rd, logic [31:0] pc);
    req_valid = 1'b1; req_op = op; req_addr = a; req_rs1_val = v;
    req_field = f; req_rd = rd; req_pc = pc;
  endtask

  // one request; on return the response is visible
  task automatic issue(logic [2:0] op, logic [11:0] a, logic [31:0] v,
                       logic [4:0] f, logic [4:0] rd, logic [31:0] pc);
    @(negedge clk);
    drive(op, a, v, f, rd, pc);
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 flush_req", {31'd0, flush_req}, 32'd1);
    check("R8 flush_pc", flush_pc, pc + 32'd4);
    check("R2 rsp_valid", {31'd0, rsp_valid}, 32'd1);
  endtask

  task automatic peek(logic [11:0] a, logic [31:0] exp, string tag);
    issue(3'b010, a, 32'hFFFF_FFFF, 5'd0, 5'd1, 32'h100);
    check(tag, rsp_rd_data, exp);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R1 flush_req", {31'd0, flush_req}, 32'd0);
    check("R1 strobes", {30'd0, csr_rd_stb, csr_wr_stb}, 32'd0);
    for (int i = 0; i < 4; i++) peek(12'(i), 32'd0, "R1 reg zero");
  endtask

  task automatic t_swap();
    issue(3'b001, 12'd1, 32'h0000_A5A5, 5'd9, 5'd3, 32'h200);
    check("R2 old value", rsp_rd_data, 32'd0);
    check("R2 rd_we", {31'd0, rsp_rd_we}, 32'd1);
    check("R2 wr_stb", {31'd0, csr_wr_stb}, 32'd1);
    check("R2 rd_idx", {27'd0, rsp_rd_idx}, 32'd3);
    check("R2 stb_idx", {30'd0, csr_stb_idx}, 32'd1);
    peek(12'd1, 32'h0000_A5A5, "R2 readback");
  endtask

  task automatic t_swap_rd0();
    issue(3'b001, 12'd2, 32'h0000_1234, 5'd4, 5'd0, 32'h300);
    check("R3 no rd_stb", {31'd0, csr_rd_stb}, 32'd0);
    check("R3 no rd_we", {31'd0, rsp_rd_we}, 32'd0);
    check("R3 wr_stb", {31'd0, csr_wr_stb}, 32'd1);
    peek(12'd2, 32'h0000_1234, "R3 readback");
  endtask

  task automatic t_set_clear();
    issue(3'b010, 12'd1, 32'h0F00_0000, 5'd7, 5'd4, 32'h400);
    check("R4 set old", rsp_rd_data, 32'h0000_A5A5);
    peek(12'd1, 32'h0F00_A5A5, "R4 set result");
    issue(3'b011, 12'd1, 32'h0000_00A5, 5'd7, 5'd4, 32'h404);
    check("R4 clear old", rsp_rd_data, 32'h0F00_A5A5);
    peek(12'd1, 32'h0F00_A500, "R4 clear result");
  endtask

  task automatic t_field0();
    issue(3'b010, 12'd1, 32'hFFFF_FFFF, 5'd0, 5'd6, 32'h500);
    check("R5 set no wr_stb", {31'd0, csr_wr_stb}, 32'd0);
    check("R5 set rd_stb", {31'd0, csr_rd_stb}, 32'd1);
    check("R5 set old", rsp_rd_data, 32'h0F00_A500);
    issue(3'b011, 12'd1, 32'hFFFF_FFFF, 5'd0, 5'd6, 32'h504);
    check("R5 clear no wr_stb", {31'd0, csr_wr_stb}, 32'd0);
    peek(12'd1, 32'h0F00_A500, "R5 unchanged");
    // R11: read with destination 0
    issue(3'b010, 12'd1, 32'h0, 5'd0, 5'd0, 32'h508);
    check("R11 rd_stb", {31'd0, csr_rd_stb}, 32'd1);
    check("R11 no rd_we", {31'd0, rsp_rd_we}, 32'd0);
  endtask

  task automatic t_zero_value();
    issue(3'b010, 12'd1, 32'h0, 5'd5, 5'd2, 32'h600);
    check("R6 set wr_stb", {31'd0, csr_wr_stb}, 32'd1);
    issue(3'b011, 12'd1, 32'h0, 5'd5, 5'd2, 32'h604);
    check("R6 clear wr_stb", {31'd0, csr_wr_stb}, 32'd1);
    peek(12'd1, 32'h0F00_A500, "R6 unchanged");
  endtask

  task automatic t_imm();
    issue(3'b101, 12'd3, 32'hFFFF_FFFF, 5'h1F, 5'd1, 32'h700);
    peek(12'd3, 32'h0000_001F, "R7 swapi zext");
    issue(3'b111, 12'd3, 32'hFFFF_FFFF, 5'h03, 5'd1, 32'h704);
    peek(12'd3, 32'h0000_001C, "R7 clri");
    issue(3'b110, 12'd3, 32'h0, 5'h01, 5'd1, 32'h708);
    check("R7 seti wr_stb", {31'd0, csr_wr_stb}, 32'd1);
    peek(12'd3, 32'h0000_001D, "R7 seti");
  endtask

  task automatic t_illegal();
    issue(3'b001, 12'h010, 32'hDEAD_BEEF, 5'd1, 5'd1, 32'h800);
    check("R9 addr illegal", {31'd0, rsp_illegal}, 32'd1);
    check("R9 addr quiet", {29'd0, csr_rd_stb, csr_wr_stb, rsp_rd_we}, 32'd0);
    issue(3'b000, 12'd0, 32'hDEAD_BEEF, 5'd1, 5'd1, 32'h804);
    check("R9 op illegal", {31'd0, rsp_illegal}, 32'd1);
    issue(3'b100, 12'd0, 32'hDEAD_BEEF, 5'd1, 5'd1, 32'h808);
    check("R9 op2 illegal", {31'd0, rsp_illegal}, 32'd1);
    check("R9 op2 quiet", {29'd0, csr_rd_stb, csr_wr_stb, rsp_rd_we}, 32'd0);
    peek(12'd0, 32'd0, "R9 reg0 unchanged");
    check("R9 legal read", {31'd0, rsp_illegal}, 32'd0);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    check("R10 ready", {31'd0, req_ready}, 32'd1);
    drive(3'b001, 12'd0, 32'h0000_0011, 5'd3, 5'd2, 32'h900);
    @(negedge clk);
    check("R10 first old", rsp_rd_data, 32'd0);
    drive(3'b010, 12'd0, 32'h0000_0100, 5'd3, 5'd2, 32'h904);
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 second sees first", rsp_rd_data, 32'h0000_0011);
    check("R10 rd and wr same rsp", {30'd0, csr_rd_stb, csr_wr_stb}, 32'd3);
    check("R8 b2b flush_pc", flush_pc, 32'h908);
    peek(12'd0, 32'h0000_0111, "R10 combined");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_swap();
    t_swap_rd0();
    t_set_clear();
    t_field0();
    t_zero_value();
    t_imm();
    t_illegal();
    t_back_to_back();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule